// File: doc/BRIEF.md
# I2C SCL Clock Timebase

This block produces the serial clock level for an I2C controller, together with one-cycle strobes that mark each edge of that clock. A shift engine next to it uses the strobes to decide when to change SDA and when to sample it. Timing comes from three 16-bit configuration values: a prescaler, a low count and a high count. The system clock is first divided by the prescaler value plus one, giving a slower tick. The low and high phases are then counted in those ticks.

Each phase lasts its configured count plus a fixed extra number of ticks. That extra number depends on the prescaler: 7 for a prescaler of 0, 6 for a prescaler of 1, and 5 for any larger value. Software normally picks a prescaler that puts the tick rate between 7 and 12 MHz, preferring the slower end. It changes the values only while the controller is held idle.

The block does not fully trust that rule. It captures all three values at the start of every clock period. A change made in the middle of a period therefore never cuts a phase short.

When disabled, the clock idles high. When enabled, the low phase comes first.

Top module: `scl_timebase`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, `scl_out` is 1 and both strobes are 0.
- R2: While enable is low, `scl_out` is 1 and no strobe pulses, apart from the rise caused by the disable itself. Enable sampled low during a running period forces `scl_out` to 1 at the next clock edge.
- R3: At the first clock edge that samples enable high while idle, `scl_out` goes to 0 and `scl_fall_stb` is 1 for that same cycle.
- R4: A low phase lasts exactly (L + d) × (P + 1) clock cycles. Here P, L and H are the prescaler, low and high values captured for that period, and d is the extra tick count.
- R5: A high phase lasts exactly (H + d) × (P + 1) clock cycles.
- R6: d is 7 when P = 0, 6 when P = 1, and 5 when P ≥ 2.
- R7: `scl_rise_stb` is 1 exactly in the cycles where `scl_out` has just gone from 0 to 1, and `scl_fall_stb` is 1 exactly in the cycles where it has just gone from 1 to 0. Each strobe lasts one cycle.
- R8: The values on `presc_val`, `low_val` and `high_val` are captured only when a period starts, which is the edge that drives `scl_out` low. A change during a period takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| enable | input | 1 | Runs the clock when 1; holds it idle high when 0 |
| presc_val | input | 16 | Prescaler value P; the tick period is P + 1 clocks |
| low_val | input | 16 | Low count L, in ticks, before d is added |
| high_val | input | 16 | High count H, in ticks, before d is added |
| scl_out | output | 1 | Serial clock level |
| scl_rise_stb | output | 1 | One-cycle pulse in the first cycle that `scl_out` is high |
| scl_fall_stb | output | 1 | One-cycle pulse in the first cycle that `scl_out` is low |

## Verification
A tick counter that runs past its limit, or a phase counter that ends one tick early or late, shows up within one period as a phase length different from (count + d) × (P + 1). A wrong choice of d produces the same kind of error, and the size of the error is a multiple of P + 1. Capturing values at the wrong moment shows up in the first phase after a mid-period change, because that phase takes the new length instead of the old one. A strobe out of step with the clock level is seen in the very cycle where the level changes.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_t;

  // Extra ticks added to each phase, chosen by the prescaler setting.
  function automatic logic [2:0] extra_ticks(input logic presc_is_zero,
                                             input logic presc_is_one);
    if (presc_is_zero)     return 3'd7;
    else if (presc_is_one) return 3'd6;
    else                   return 3'd5;
  endfunction

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
  parameter int W      = 16,
  parameter int FIELDS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [FIELDS-1:0][W-1:0]  cfg_i,
  output logic [FIELDS-1:0][W-1:0]  cfg_o
);
  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    logic [W-1:0] field_q, field_d;

    always_comb begin
      field_d = field_q;
      if (load_i) field_d = cfg_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) field_q <= '0;
      else        field_q <= field_d;
    end

    assign cfg_o[g] = field_q;
  end
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] presc_i,
  output logic         tick_o
);
  logic [W-1:0] pre_q, pre_d;

  assign tick_o = run_i && (pre_q == presc_i);

  always_comb begin
    pre_d = pre_q + 1'b1;
    if (!run_i || tick_o) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // The tick counter never passes the captured prescaler limit.
  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pre_q <= presc_i));

  // While idle, the counter sits at zero.
  assert_pre_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] presc_i,
  input  logic [W-1:0] low_i,
  input  logic [W-1:0] high_i,
  output logic         load_o,
  output logic         run_o,
  output logic         scl_o,
  output logic         rise_o,
  output logic         fall_o
);
  localparam int CW = W + 1;

  scl_phase_t    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          scl_q, scl_d, rise_q, rise_d, fall_q, fall_d;
  logic [2:0]    d_extra;
  logic [CW-1:0] low_last, high_last, cur_last;

  assign d_extra   = extra_ticks(presc_i == '0, presc_i == W'(1));
  assign low_last  = {1'b0, low_i}  + CW'(d_extra) - 1'b1;
  assign high_last = {1'b0, high_i} + CW'(d_extra) - 1'b1;
  assign cur_last  = (phase_q == PH_HIGH) ? high_last : low_last;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    scl_d   = scl_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    load_o  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        scl_d = 1'b1;
        cnt_d = '0;
        if (en_i) begin
          phase_d = PH_LOW;
          scl_d   = 1'b0;
          fall_d  = 1'b1;
          load_o  = 1'b1;
        end
      end
      PH_LOW: begin
        if (!en_i) begin
          phase_d = PH_IDLE;
          scl_d   = 1'b1;
          rise_d  = 1'b1;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == low_last) begin
            phase_d = PH_HIGH;
            scl_d   = 1'b1;
            rise_d  = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_HIGH: begin
        if (!en_i) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == high_last) begin
            phase_d = PH_LOW;
            scl_d   = 1'b0;
            fall_d  = 1'b1;
            load_o  = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        scl_d   = 1'b1;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      scl_q   <= 1'b1;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      scl_q   <= scl_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign run_o  = (phase_q != PH_IDLE);
  assign scl_o  = scl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // Tick counter stays inside the current phase length.
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (cnt_q <= cur_last));

  // Enable seen low always leaves the line high.
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> scl_o);

  // Strobes follow the line level.
  assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (scl_o && !$past(scl_o)));
  assert_fall_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!scl_o && $past(scl_o)));
  assert_level_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && !$past(scl_o)) |-> rise_o);
  assert_level_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_o && $past(scl_o)) |-> fall_o);
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/scl_timebase.sv
module scl_timebase
  import scl_div_pkg::*;
#(
  parameter int REG_W      = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [REG_W-1:0] presc_val,
  input  logic [REG_W-1:0] low_val,
  input  logic [REG_W-1:0] high_val,
  output logic             scl_out,
  output logic             scl_rise_stb,
  output logic             scl_fall_stb
);
  localparam int N_CFG  = 3;
  localparam int IDX_PS = 0;
  localparam int IDX_LO = 1;
  localparam int IDX_HI = 2;

  logic                          rst_int_n;
  logic                          load_w, run_w, tick_w;
  logic [N_CFG-1:0][REG_W-1:0]   cfg_in, cfg_lat;

  assign cfg_in[IDX_PS] = presc_val;
  assign cfg_in[IDX_LO] = low_val;
  assign cfg_in[IDX_HI] = high_val;

  scl_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  scl_cfg_latch #(.W(REG_W), .FIELDS(N_CFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load_w),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_lat)
  );

  scl_tick_gen #(.W(REG_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_i   (run_w),
    .presc_i (cfg_lat[IDX_PS]),
    .tick_o  (tick_w)
  );

  scl_phase_fsm #(.W(REG_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (enable),
    .tick_i  (tick_w),
    .presc_i (cfg_lat[IDX_PS]),
    .low_i   (cfg_lat[IDX_LO]),
    .high_i  (cfg_lat[IDX_HI]),
    .load_o  (load_w),
    .run_o   (run_w),
    .scl_o   (scl_out),
    .rise_o  (scl_rise_stb),
    .fall_o  (scl_fall_stb)
  );

  // Captured settings move only at a period start.
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run_w && !scl_fall_stb) |-> $stable(cfg_lat));

  // Leaving idle always begins with the low phase.
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(run_w) |-> (scl_fall_stb && !scl_out));
endmodule

// File: tb/scl_timebase_tb.sv
module scl_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [15:0] presc_val, low_val, high_val;
  logic        scl_out, scl_rise_stb, scl_fall_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam int LIMIT = 100000;

  always #4 clk = ~clk;

  scl_timebase u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .presc_val    (presc_val),
    .low_val      (low_val),
    .high_val     (high_val),
    .scl_out      (scl_out),
    .scl_rise_stb (scl_rise_stb),
    .scl_fall_stb (scl_fall_stb)
  );

  function automatic int d_of(input int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  function automatic int phase_len(input int p, input int n);
    return (n + d_of(p)) * (p + 1);
  endfunction

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Strobe monitor (R7): compares each strobe with the level change.
  logic prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check(scl_rise_stb == (!prev_scl && scl_out), "R7 rise strobe",
            scl_rise_stb, !prev_scl && scl_out);
      check(scl_fall_stb == (prev_scl && !scl_out), "R7 fall strobe",
            scl_fall_stb, prev_scl && !scl_out);
    end
    prev_scl = scl_out;
  end

  // Entered at a negedge where scl just became lvl; returns at the negedge
  // where it changed.
  task automatic meas(input logic lvl, input int exp, input string req);
    int n = 1;
    @(negedge clk);
    while (scl_out === lvl && n < LIMIT) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic run_cfg(input int p, input int l, input int h,
                         input int p2, input int l2, input int h2);
    presc_val = 16'(p); low_val = 16'(l); high_val = 16'(h);
    enable = 1'b1;
    @(negedge clk);
    check(scl_out == 1'b0 && scl_fall_stb == 1'b1, "R3 start low",
          {scl_out, scl_fall_stb}, 2'b01);
    // Mid-period change (R8): takes effect only at the next period.
    presc_val = 16'(p2); low_val = 16'(l2); high_val = 16'(h2);
    meas(1'b0, phase_len(p, l),  "R4 low length");
    meas(1'b1, phase_len(p, h),  "R5 high length R6 R8");
    meas(1'b0, phase_len(p2, l2), "R4 low length R8");
    meas(1'b1, phase_len(p2, h2), "R5 high length");
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_out == 1'b1 && scl_rise_stb == 1'b1, "R2 disable mid low",
          {scl_out, scl_rise_stb}, 2'b11);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(scl_out == 1'b1 && !scl_rise_stb && !scl_fall_stb, "R2 idle",
            {scl_out, scl_rise_stb, scl_fall_stb}, 3'b100);
    end
  endtask

  initial begin
    #(8 * 180000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; enable = 1'b0;
    presc_val = '0; low_val = '0; high_val = '0;
    repeat (3) @(negedge clk);
    check(scl_out == 1'b1 && !scl_rise_stb && !scl_fall_stb, "R1 in reset",
          {scl_out, scl_rise_stb, scl_fall_stb}, 3'b100);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(scl_out == 1'b1 && !scl_rise_stb && !scl_fall_stb, "R1 after reset",
            {scl_out, scl_rise_stb, scl_fall_stb}, 3'b100);
    end
    // Settings changed while idle must not cause activity (R2).
    presc_val = 16'd3; low_val = 16'd9; high_val = 16'd2;
    repeat (4) begin
      @(negedge clk);
      check(scl_out == 1'b1, "R2 idle config change", scl_out, 1);
    end

    // Directed: each d value (R6), zero counts, large prescaler.
    run_cfg(0, 0, 0, 0, 0, 0);
    run_cfg(1, 3, 4, 1, 3, 4);
    run_cfg(2, 5, 1, 2, 5, 1);
    run_cfg(200, 0, 2, 200, 0, 2);
    run_cfg(0, 300, 1, 0, 300, 1);
    // Mid-period changes across d classes (R8, R6).
    run_cfg(0, 2, 3, 3, 1, 0);
    run_cfg(5, 1, 1, 1, 6, 2);

    // Random configurations.
    for (int k = 0; k < 8; k++) begin
      int p, l, h, p2, l2, h2;
      p  = int'($urandom_range(0, 6));  l  = int'($urandom_range(0, 20));
      h  = int'($urandom_range(0, 20)); p2 = int'($urandom_range(0, 6));
      l2 = int'($urandom_range(0, 20)); h2 = int'($urandom_range(0, 20));
      run_cfg(p, l, h, p2, l2, h2);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule